// File: doc/BRIEF.md
# SDRAM Command Timing Sequencer

This block turns single-word read and write requests for one chip select into SDRAM commands. An access opens a row with ACTIVE, then issues READ or WRITE with auto-precharge, and waits for the precharge to complete. A single-bit request from a refresh timer is held pending and served between accesses with AUTO REFRESH. Every gap between commands comes from a packed 16-bit timing word. An 8-bit memory configuration word selects the column width and the bank count. From those two settings the block splits the flat word address into row, bank and column.

The requester raises `req_valid` with the address, the write flag and the write data, and holds them until `done` pulses. For a read, `rd_data` is valid in the `done` cycle. A request is refused for as long as `cfg_err` is high. Commands appear on `sd_cmd` with this encoding: NOP = 0, ACTIVE = 1, READ = 2, WRITE = 3, AUTO REFRESH = 4.

The controller has ten states: S_IDLE, S_ACT, S_RCD, S_RW, S_LAT, S_RAS, S_PRE, S_FIN, S_REF and S_RFC.
- From S_IDLE, a pending refresh leads to S_REF. Otherwise an acceptable request leads to S_ACT.
- From S_ACT, the block goes to S_RCD if the row-to-column delay exceeds one cycle, and straight to S_RW if not.
- S_RCD moves to S_RW when its counter expires. S_RW always moves to S_LAT.
- S_LAT leaves when its counter expires. It goes to S_PRE if the minimum row-active time is already met, and to S_RAS if not.
- S_RAS moves to S_PRE once the row-active time is met.
- S_PRE moves to S_FIN when its counter expires. S_FIN always returns to S_IDLE.
- S_REF always moves to S_RFC. S_RFC returns to S_IDLE when its counter expires.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset, `sd_cmd` is NOP (0) and `done` is low.
- R2: An access issues exactly two commands. The first is ACTIVE (1). READ (2) or WRITE (3) follows `trcd` cycles later, where `trcd` is timing bits 14:12 plus one. With no refresh pending and no turnaround owed, ACTIVE comes in the cycle after the first idle cycle in which `req_valid` is seen.
- R3: A read captures `sd_dq_in` `cl` cycles after the READ cycle, where `cl` is timing bits 10:8 plus one. The captured word is on `rd_data` while `done` is high.
- R4: WRITE drives the request's write data on `sd_wdata`. The write recovery time `twr` is timing bits 5:4 plus one, for codes 1 to 3.
- R5: The precharge phase starts no sooner than `tras` cycles after ACTIVE. `tras` comes from timing bits 3:2: codes 0, 1, 2 and 3 give 1, 2, 5 and 6 cycles.
- R6: The precharge phase lasts `trp` cycles. `trp` comes from timing bits 1:0 with the same 1/2/5/6 mapping. `done` is high for one cycle, and that cycle comes `max(trcd+N+1, tras) + trp` cycles after ACTIVE, with N = `cl` for a read and N = `twr` for a write.
- R7: During ACTIVE, `sd_addr` carries the row and `sd_ba` carries the bank. The column width is 8 + config bits 5:4 (config bit 6 clear). The bank field above it is 1 bit wide if config bit 2 is 0 and 2 bits wide if it is 1. The row is made of the address bits above the bank field.
- R8: During READ and WRITE, `sd_addr` bits 9:0 carry the low column bits and bit 10 is 1 (auto-precharge). Bit 11 carries column bit 10 in the 11-bit column mode and is 0 in the other modes.
- R9: A write request that follows a completed read waits. It is accepted only when `rtw` idle cycles have passed since the read finished, where `rtw` is timing bits 7:6 plus one.
- R10: A `ref_req` pulse is latched and served only from idle, ahead of any request. It issues AUTO REFRESH (4), then REF_CYCLES cycles with no command before the block is idle again.
- R11: `cfg_err` is high when timing bits 5:4 are 0 or config bit 6 is 1. While it is high, no ACTIVE is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tim_cfg | input | 16 | Packed timing word |
| mem_cfg | input | 8 | Memory configuration word |
| req_valid | input | 1 | Request present, held until done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid with done |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Invalid configuration, requests refused |
| ref_req | input | 1 | Refresh request pulse |
| sd_cmd | output | 3 | SDRAM command code |
| sd_addr | output | SD_ADDR_W | SDRAM address pins |
| sd_ba | output | 2 | SDRAM bank select |
| sd_wdata | output | DATA_W | Data driven with WRITE |
| sd_dq_in | input | DATA_W | Data returned by the SDRAM |

## Verification
Directed accesses use three timing words.
- The shortest-timing word exposes off-by-one errors in the wait states.
- The longest-timing word shows that every field reaches its counter.
- A word with short column timing but the longest row-active time forces the S_RAS extension. This separates the `tras` rule from the plain latency path.

Random accesses then mix every valid timing code, every column width and both bank counts, with reads and writes at random idle gaps. These show that the fields are decoded independently and that the address is sliced correctly in each mode. Read-then-write pairs with gaps shorter than `rtw` exercise the turnaround hold. Separate directed cases cover the following:
- refresh arriving before a request;
- each of the two configuration errors.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_REF = 3'd4
    } sd_cmd_e;

    typedef enum logic [3:0] {
        S_IDLE, S_ACT, S_RCD, S_RW, S_LAT, S_RAS, S_PRE, S_FIN, S_REF, S_RFC
    } seq_state_e;

    typedef struct packed {
        logic [3:0] trp;
        logic [3:0] tras;
        logic [3:0] twr;
        logic [3:0] rtw;
        logic [3:0] cl;
        logic [3:0] trcd;
    } seq_timing_t;

    function automatic logic [3:0] row_time(input logic [1:0] code);
        logic [3:0] v;
        unique case (code)
            2'd0: v = 4'd1;
            2'd1: v = 4'd2;
            2'd2: v = 4'd5;
            default: v = 4'd6;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/sdram_tim_decode.sv
module sdram_tim_decode
    import sdram_seq_pkg::*;
(
    input  logic [15:0]  tim_word,
    output seq_timing_t  tim,
    output logic         twr_bad
);
    logic unused_reserved;
    assign unused_reserved = tim_word[11] ^ tim_word[15];

    always_comb begin
        tim.trp  = row_time(tim_word[1:0]);
        tim.tras = row_time(tim_word[3:2]);
        tim.twr  = {2'b00, tim_word[5:4]} + 4'd1;
        tim.rtw  = {2'b00, tim_word[7:6]} + 4'd1;
        tim.cl   = {1'b0, tim_word[10:8]} + 4'd1;
        tim.trcd = {1'b0, tim_word[14:12]} + 4'd1;
        twr_bad  = (tim_word[5:4] == 2'b00);
    end
endmodule

// File: rtl/sdram_addr_split.sv
module sdram_addr_split #(
    parameter int ADDR_W    = 24,
    parameter int SD_ADDR_W = 13
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [1:0]           page_code,
    input  logic                 four_banks,
    output logic [SD_ADDR_W-1:0] row,
    output logic [1:0]           bank,
    output logic [SD_ADDR_W-1:0] col_pins
);
    localparam int COL_MAX = 11;

    int                col_w;
    int                bank_w;
    logic [ADDR_W-1:0] col;
    logic [ADDR_W-1:0] above_col;

    always_comb begin
        col_w     = 8 + int'(page_code);
        bank_w    = four_banks ? 2 : 1;
        col       = addr & ~({ADDR_W{1'b1}} << col_w);
        above_col = addr >> col_w;
        bank      = above_col[1:0] & {four_banks, 1'b1};
        row       = SD_ADDR_W'(addr >> (col_w + bank_w));
        col_pins        = '0;
        col_pins[9:0]   = col[9:0];
        col_pins[10]    = 1'b1;
        col_pins[COL_MAX-0] = col[10];
    end
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 16,
    parameter int SD_ADDR_W  = 13,
    parameter int REF_CYCLES = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          tim_cfg,
    input  logic [7:0]           mem_cfg,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 done,
    output logic                 cfg_err,
    input  logic                 ref_req,
    output logic [2:0]           sd_cmd,
    output logic [SD_ADDR_W-1:0] sd_addr,
    output logic [1:0]           sd_ba,
    output logic [DATA_W-1:0]    sd_wdata,
    input  logic [DATA_W-1:0]    sd_dq_in
);
    localparam int RC_W  = $clog2(REF_CYCLES + 1);
    localparam int CNT_W = (RC_W > 4) ? RC_W : 4;
    localparam int AGE_W = 5;

    seq_state_e             state, nxt;
    seq_timing_t            tim;
    logic                   twr_bad;
    logic [CNT_W-1:0]       cnt;
    logic [AGE_W-1:0]       age;
    logic [3:0]             turn;
    logic                   ref_pend;
    logic                   acc_wr;
    logic [ADDR_W-1:0]      acc_addr;
    logic [DATA_W-1:0]      acc_wdata;
    logic [DATA_W-1:0]      rd_q;
    logic [SD_ADDR_W-1:0]   row;
    logic [SD_ADDR_W-1:0]   col_pins;
    logic [1:0]             bank;
    logic                   ras_ok;
    logic                   accept;
    logic                   unused_cfg;

    assign unused_cfg = ^{mem_cfg[7], mem_cfg[3], mem_cfg[1:0]};

    sdram_tim_decode tim_i (
        .tim_word (tim_cfg),
        .tim      (tim),
        .twr_bad  (twr_bad)
    );

    sdram_addr_split #(
        .ADDR_W    (ADDR_W),
        .SD_ADDR_W (SD_ADDR_W)
    ) split_i (
        .addr       (acc_addr),
        .page_code  (mem_cfg[5:4]),
        .four_banks (mem_cfg[2]),
        .row        (row),
        .bank       (bank),
        .col_pins   (col_pins)
    );

    assign cfg_err = twr_bad | mem_cfg[6];
    assign ras_ok  = ({1'b0, age} + 6'd1) >= 6'(tim.tras);
    assign accept  = req_valid && !cfg_err && !(req_write && turn != 4'd0);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (ref_pend)    nxt = S_REF;
                else if (accept) nxt = S_ACT;
            end
            S_ACT:  nxt = (tim.trcd > 4'd1) ? S_RCD : S_RW;
            S_RCD:  if (cnt == '0) nxt = S_RW;
            S_RW:   nxt = S_LAT;
            S_LAT:  if (cnt == '0) nxt = ras_ok ? S_PRE : S_RAS;
            S_RAS:  if (ras_ok) nxt = S_PRE;
            S_PRE:  if (cnt == '0) nxt = S_FIN;
            S_FIN:  nxt = S_IDLE;
            S_REF:  nxt = S_RFC;
            S_RFC:  if (cnt == '0) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // wait counters, request latch and capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            age       <= '0;
            turn      <= '0;
            ref_pend  <= 1'b0;
            acc_wr    <= 1'b0;
            acc_addr  <= '0;
            acc_wdata <= '0;
            rd_q      <= '0;
        end else begin
            if (nxt != state) begin
                unique case (nxt)
                    S_RCD:   cnt <= CNT_W'(tim.trcd) - CNT_W'(2);
                    S_LAT:   cnt <= (acc_wr ? CNT_W'(tim.twr) : CNT_W'(tim.cl)) - CNT_W'(1);
                    S_PRE:   cnt <= CNT_W'(tim.trp) - CNT_W'(1);
                    S_RFC:   cnt <= CNT_W'(REF_CYCLES - 1);
                    default: cnt <= cnt;
                endcase
            end else if (cnt != '0) begin
                cnt <= cnt - CNT_W'(1);
            end

            if (state == S_ACT)        age <= AGE_W'(1);
            else if (age != '1)        age <= age + AGE_W'(1);

            if (state == S_FIN && !acc_wr) turn <= tim.rtw;
            else if (turn != 4'd0)         turn <= turn - 4'd1;

            ref_pend <= ref_req | (ref_pend & (state != S_REF));

            if (state == S_IDLE && nxt == S_ACT) begin
                acc_wr    <= req_write;
                acc_addr  <= req_addr;
                acc_wdata <= req_wdata;
            end

            if (state == S_LAT && cnt == '0 && !acc_wr) rd_q <= sd_dq_in;
        end
    end

    // outputs
    always_comb begin
        sd_cmd  = CMD_NOP;
        sd_addr = '0;
        sd_ba   = 2'b00;
        done    = 1'b0;
        unique case (state)
            S_ACT: begin
                sd_cmd  = CMD_ACT;
                sd_addr = row;
                sd_ba   = bank;
            end
            S_RW: begin
                sd_cmd  = acc_wr ? CMD_WR : CMD_RD;
                sd_addr = col_pins;
                sd_ba   = bank;
            end
            S_REF:   sd_cmd = CMD_REF;
            S_FIN:   done   = 1'b1;
            default: ;
        endcase
    end

    assign rd_data  = rd_q;
    assign sd_wdata = acc_wdata;

    // R2: column command only once the row-to-column delay has elapsed
    assert_rcd_met_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_RD || sd_cmd == CMD_WR) |-> (age >= AGE_W'(tim.trcd)));

    // R5: precharge never starts before the row-active time
    assert_ras_met_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PRE && $past(state) != S_PRE) |-> (age >= AGE_W'(tim.tras)));

    // R6: completion is a single-cycle pulse
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: column commands always request auto-precharge
    assert_ap_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_RD || sd_cmd == CMD_WR) |-> sd_addr[10]);

    // R11: no row is opened while the configuration is invalid
    assert_no_act_on_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && cfg_err) |=> (sd_cmd != CMD_ACT));

endmodule

// File: tb/sdram_cmd_seq_tb.sv
module sdram_cmd_seq_tb_top;
    localparam int RC = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tim_cfg = 16'h0010;
    logic [7:0]  mem_cfg = 8'h00;
    logic        req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0, sd_dq_in = '0;
    logic [15:0] rd_data, sd_wdata;
    logic        done, cfg_err;
    logic [2:0]  sd_cmd;
    logic [12:0] sd_addr;
    logic [1:0]  sd_ba;

    int n_chk = 0, n_fail = 0;
    bit last_rd = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    sdram_cmd_seq #(.ADDR_W(24), .DATA_W(16), .SD_ADDR_W(13), .REF_CYCLES(RC)) dut_i (
        .clk(clk), .rst_n(rst_n), .tim_cfg(tim_cfg), .mem_cfg(mem_cfg),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd_data), .done(done), .cfg_err(cfg_err),
        .ref_req(ref_req), .sd_cmd(sd_cmd), .sd_addr(sd_addr), .sd_ba(sd_ba),
        .sd_wdata(sd_wdata), .sd_dq_in(sd_dq_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rowt(input int code);
        return (code < 2) ? code + 1 : code + 3;
    endfunction

    task automatic access(input bit wr, input logic [23:0] ad, input logic [15:0] wd,
                          input int gap, input logic [15:0] tw, input logic [7:0] mc);
        int k = 0, a = -1, r = -1, f = -1, ncmd = 0;
        int trcd, cl, twr, tras, trp, rtw, cw, bw, extra, p, expf;
        int col, bnk, rowv, ecol;
        logic [15:0] dv;
        tim_cfg = tw;
        mem_cfg = mc;
        trp  = rowt(int'(tw[1:0]));
        tras = rowt(int'(tw[3:2]));
        twr  = int'(tw[5:4]) + 1;
        rtw  = int'(tw[7:6]) + 1;
        cl   = int'(tw[10:8]) + 1;
        trcd = int'(tw[14:12]) + 1;
        cw   = 8 + int'(mc[5:4]);
        bw   = mc[2] ? 2 : 1;
        col  = int'(ad) % (1 << cw);
        bnk  = (int'(ad) / (1 << cw)) % (1 << bw);
        rowv = (int'(ad) / (1 << (cw + bw))) % 8192;
        ecol = (col % 1024) + 1024 + ((cw == 11) ? ((col / 1024) % 2) * 2048 : 0);
        extra = (last_rd && wr) ? ((rtw - gap > 0) ? rtw - gap : 0) : 0;
        dv = 16'($urandom);
        repeat (gap + 1) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = ad; req_wdata = wd;
        chk(cfg_err == 1'b0, "R11 cfg_err low on valid config", int'(cfg_err), 0);
        while (f < 0 && k < 150) begin
            @(negedge clk);
            k++;
            if (sd_cmd != 3'd0) ncmd++;
            if (sd_cmd == 3'd1) begin
                a = k;
                chk(sd_addr == 13'(rowv), "R7 row on ACTIVE", int'(sd_addr), rowv);
                chk(sd_ba == 2'(bnk), "R7 bank on ACTIVE", int'(sd_ba), bnk);
            end
            if (sd_cmd == 3'd2 || sd_cmd == 3'd3) begin
                r = k;
                chk(sd_cmd == (wr ? 3'd3 : 3'd2), "R2 column command kind", int'(sd_cmd), wr ? 3 : 2);
                chk(sd_addr == 13'(ecol), "R8 column pins", int'(sd_addr), ecol);
                chk(sd_ba == 2'(bnk), "R7 bank on column command", int'(sd_ba), bnk);
                if (wr) chk(sd_wdata == wd, "R4 write data", int'(sd_wdata), int'(wd));
            end
            if (!wr && r >= 0 && k == r + cl) sd_dq_in = dv;
            else                              sd_dq_in = 16'($urandom);
            if (done) f = k;
        end
        req_valid = 1'b0;
        p = trcd + (wr ? twr : cl) + 1;
        expf = ((p > tras) ? p : tras) + trp;
        if (last_rd && wr) chk(a == 1 + extra, "R9 read-to-write hold", a, 1 + extra);
        else               chk(a == 1 + extra, "R2 ACTIVE latency", a, 1 + extra);
        chk(r - a == trcd, "R2 row-to-column delay", r - a, trcd);
        chk(ncmd == 2, "R2 command count", ncmd, 2);
        chk(f - a == expf, "R6 done cycle (with R4, R5)", f - a, expf);
        if (!wr) chk(rd_data == dv, "R3 read data at CAS latency", int'(rd_data), int'(dv));
        last_rd = !wr;
    endtask

    task automatic ref_case();
        int k = 0, kref = -1, kact = -1, ncmd = 0;
        @(negedge clk);
        ref_req = 1'b1;
        @(negedge clk);
        k = 1;
        ref_req = 1'b0;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 24'h00_1234;
        while (!done && k < 150) begin
            @(negedge clk);
            k++;
            if (sd_cmd != 3'd0) ncmd++;
            if (sd_cmd == 3'd4 && kref < 0) kref = k;
            if (sd_cmd == 3'd1 && kact < 0) kact = k;
        end
        req_valid = 1'b0;
        chk(kref == 2, "R10 refresh issued first", kref, 2);
        chk(kact == 4 + RC, "R10 idle cycles after refresh", kact, 4 + RC);
        chk(ncmd == 3, "R10 no command during refresh wait", ncmd, 3);
        last_rd = 1;
    endtask

    task automatic err_case(input logic [15:0] tw, input logic [7:0] mc, input string tag);
        int nact = 0;
        @(negedge clk);
        tim_cfg = tw; mem_cfg = mc;
        req_valid = 1'b1; req_write = 1'b0;
        repeat (25) begin
            @(negedge clk);
            if (sd_cmd == 3'd1) nact++;
        end
        chk(cfg_err == 1'b1, {tag, " cfg_err raised"}, int'(cfg_err), 1);
        chk(nact == 0, {tag, " no ACTIVE while in error"}, nact, 0);
        req_valid = 1'b0;
        last_rd = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(sd_cmd == 3'd0, "R1 NOP in reset", int'(sd_cmd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sd_cmd == 3'd0, "R1 NOP after reset", int'(sd_cmd), 0);
        chk(done == 1'b0, "R1 done low after reset", int'(done), 0);

        // shortest timings, then a write owed the longest turnaround
        access(1'b0, 24'h00_0123, 16'h0, 0, 16'h0010, 8'h00);
        access(1'b1, 24'h00_0456, 16'hBEEF, 0, 16'h00D0, 8'h00);
        // forced row-active extension
        access(1'b0, 24'h12_3456, 16'h0, 2, 16'h001C, 8'h04);
        access(1'b1, 24'h12_3457, 16'h5A5A, 1, 16'h001C, 8'h14);
        // longest timings, 11-bit columns, four banks
        access(1'b1, 24'hAB_CDEF, 16'h1357, 0, 16'h77FF, 8'h34);
        access(1'b0, 24'hAB_CDEF, 16'h0, 0, 16'h77FF, 8'h34);
        access(1'b1, 24'hAB_CDEE, 16'h2468, 2, 16'h77FF, 8'h30);

        ref_case();

        err_case(16'h4305, 8'h00, "R11 write recovery code 0");
        err_case(16'h4315, 8'h40, "R11 page code invalid");

        for (int i = 0; i < 60; i++) begin
            logic [15:0] tw;
            logic [7:0]  mc;
            tw = {1'b0, 3'($urandom), 1'b0, 3'($urandom), 2'($urandom),
                  2'(1 + ($urandom % 3)), 2'($urandom), 2'($urandom)};
            mc = {2'b00, 2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom)};
            access(1'($urandom), 24'($urandom), 16'($urandom), int'($urandom % 4), tw, mc);
        end

        ref_case();

        ended = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule